// File: doc/BRIEF.md
# Lane-wise Vector Byte Shifter

This block is the data result path of a whole-byte left shift on a wide vector register. The vector is split into 128-bit lanes. Each active lane is shifted left by the same byte count, and zeros fill the low bytes that the shift empties. No byte ever moves from one lane into the next. A count of 16 or more clears an active lane.

A two-bit length select picks how many lanes are active: one, two or all four. Result bits above the active length are either cleared or carried over from the old destination value. The legacy flag chooses between these two behaviours. It has an effect only at the 128-bit length, and there it also makes the old destination the data that is shifted.

A parameter selects whether the result leaves the block through a register stage, one cycle after an input strobe, or straight from the logic. Instruction decode, memory operands, masking and flags are handled outside the block.

Top module: `vec_byte_shifter`

## Requirements
- R1: For an active lane and a count c below 16, result byte j of that lane equals byte j-c of the lane's input when j >= c, and zero when j < c (byte 0 is the lane's least significant byte).
- R2: A count of 16 or more, anywhere in 16..255, makes every active lane all zeros.
- R3: When `vlen` is 2 (512 bits), all four lanes are shifted, each on its own data, and no byte crosses a 128-bit lane boundary.
- R4: When `vlen` is 1 (256 bits), lanes 0 and 1 are shifted and result bits 511:256 are zero.
- R5: When `vlen` is 0 (128 bits) and `legacy` is 0, lane 0 is shifted from `src` and result bits 511:128 are zero.
- R6: When `vlen` is 0 and `legacy` is 1, lane 0 is shifted from `old_dst[127:0]`, result bits 511:128 equal `old_dst[511:128]`, and `src` has no effect on the result.
- R7: When `vlen` is 1 or 2, `legacy` has no effect on the result.
- R8: The spare `vlen` code 3 behaves exactly like code 2.
- R9: With `REG_OUT`=1, `result` and `out_valid` show an input on the cycle after the clock edge that samples `in_valid`=1. `out_valid` is 0 after an edge that samples `in_valid`=0.
- R10: With `REG_OUT`=1, `result` holds its value across every edge at which `in_valid` is 0.
- R11: Synchronous active-low reset clears `result` and `out_valid` to zero when `REG_OUT`=1.
- R12: With `REG_OUT`=0, `result` follows the inputs within the same cycle and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe; loads the output register |
| src | input | 512 | Vector to be shifted |
| old_dst | input | 512 | Previous destination value |
| count | input | 8 | Shift amount in bytes |
| vlen | input | 2 | Active length: 0 = 128, 1 = 256, 2 or 3 = 512 bits |
| legacy | input | 1 | 128-bit in-place mode that keeps the upper bits |
| out_valid | output | 1 | Result strobe |
| result | output | 512 | Shifted vector |

## Verification
The bench builds two instances side by side. The first uses `REG_OUT`=1, which brings the one-cycle timing, the hold between strobes and the reset clearing within reach. The second uses `REG_OUT`=0, so the same stimulus can be checked against the logic within the same cycle. Both instances use the default of four 128-bit lanes and an 8-bit count. The stimulus therefore covers every length code, both legacy settings, and the saturating counts 16 and 255 next to the in-range edges 0, 1 and 15.

// File: rtl/vbs_pkg.sv
// Package: shared encodings for the lane-wise vector byte shifter.
// Assumes a two-bit length select; code 3 is spare and treated as full width.
package vbs_pkg;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_SPARE = 2'd3
    } vlen_e;

endpackage

// File: rtl/vbs_lane_shift.sv
// Module: vbs_lane_shift
// Shifts one lane left by whole bytes with zero fill, built as a log-depth
// barrel. Counts of LANE_BYTES or more clear the lane.
// Assumes LANE_BYTES is a power of two.
module vbs_lane_shift #(
    parameter int LANE_BYTES = 16,
    parameter int COUNT_W    = 8
) (
    input  logic [LANE_BYTES*8-1:0] lane_in,
    input  logic [COUNT_W-1:0]      count,
    output logic [LANE_BYTES*8-1:0] lane_out
);
    localparam int LANE_W = LANE_BYTES * 8;
    localparam int SH_W   = $clog2(LANE_BYTES);

    logic [LANE_W-1:0] stage [0:SH_W];
    logic              saturate;

    assign stage[0] = lane_in;

    // Each stage moves the data by 2^k bytes when count bit k is set.
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        assign stage[k+1] = count[k] ? (stage[k] << ((1 << k) * 8)) : stage[k];
    end

    // Count beyond the last byte position empties the lane.
    always_comb begin
        saturate = (count > COUNT_W'(LANE_BYTES - 1));
        lane_out = saturate ? '0 : stage[SH_W];
    end

endmodule

// File: rtl/vbs_lane_ctrl.sv
// Module: vbs_lane_ctrl
// Decodes length select and legacy flag into per-lane enables and the
// upper-bits policy. The legacy flag only counts at the single-lane length.
module vbs_lane_ctrl
    import vbs_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic [1:0]           vlen,
    input  logic                 legacy,
    output logic [NUM_LANES-1:0] lane_on,
    output logic                 keep_old,
    output logic                 src_from_old
);
    int unsigned lanes_used;

    // Number of lanes taking part for the selected length.
    always_comb begin
        case (vlen_e'(vlen))
            VL_128:  lanes_used = 1;
            VL_256:  lanes_used = (NUM_LANES < 2) ? NUM_LANES : 2;
            default: lanes_used = NUM_LANES;
        endcase
    end

    // Lane enable mask from the lane count.
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_on
        assign lane_on[i] = (i < lanes_used);
    end

    // Legacy in-place behaviour applies only at the 128-bit length.
    always_comb begin
        keep_old     = legacy && (vlen_e'(vlen) == VL_128);
        src_from_old = keep_old;
    end

endmodule

// File: rtl/vbs_out_stage.sv
// Module: vbs_out_stage
// Optional output register. With REG_OUT set, the data loads on a strobe
// and holds otherwise; the strobe is delayed by one cycle. Without it the
// stage is a wire.
module vbs_out_stage #(
    parameter int W       = 512,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] d,
    output logic         out_valid,
    output logic [W-1:0] q
);
    if (REG_OUT) begin : g_reg
        // Capture on strobe, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                q         <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) q <= d;
            end
        end
    end else begin : g_wire
        assign out_valid = in_valid;
        assign q         = d;
    end

endmodule

// File: rtl/vec_byte_shifter.sv
// Module: vec_byte_shifter (top)
// Lane-wise byte left shift of a wide vector with zero fill. Upper bits
// past the active length are cleared or kept from the old destination.
// Assumes the length select maps codes 0/1/2 to 1/2/all lanes; 3 = all lanes.
module vec_byte_shifter #(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 128,
    parameter int COUNT_W   = 8,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [NUM_LANES*LANE_W-1:0] src,
    input  logic [NUM_LANES*LANE_W-1:0] old_dst,
    input  logic [COUNT_W-1:0]          count,
    input  logic [1:0]                  vlen,
    input  logic                        legacy,
    output logic                        out_valid,
    output logic [NUM_LANES*LANE_W-1:0] result
);
    localparam int VEC_W      = NUM_LANES * LANE_W;
    localparam int LANE_BYTES = LANE_W / 8;

    logic [NUM_LANES-1:0] lane_on;
    logic                 keep_old;
    logic                 src_from_old;
    logic [VEC_W-1:0]     merged;

    vbs_lane_ctrl #(.NUM_LANES(NUM_LANES)) u_ctrl (
        .vlen         (vlen),
        .legacy       (legacy),
        .lane_on      (lane_on),
        .keep_old     (keep_old),
        .src_from_old (src_from_old)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] lane_in;
        logic [LANE_W-1:0] lane_sh;

        // Lane 0 shifts the old destination in legacy in-place mode.
        if (i == 0) begin : g_first
            assign lane_in = src_from_old ? old_dst[LANE_W-1:0] : src[LANE_W-1:0];
        end else begin : g_rest
            assign lane_in = src[i*LANE_W +: LANE_W];
        end

        vbs_lane_shift #(.LANE_BYTES(LANE_BYTES), .COUNT_W(COUNT_W)) u_shift (
            .lane_in  (lane_in),
            .count    (count),
            .lane_out (lane_sh)
        );

        // Active lanes take the shift; inactive ones are cleared or kept.
        assign merged[i*LANE_W +: LANE_W] =
            lane_on[i] ? lane_sh :
            (keep_old  ? old_dst[i*LANE_W +: LANE_W] : '0);
    end

    vbs_out_stage #(.W(VEC_W), .REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d         (merged),
        .out_valid (out_valid),
        .q         (result)
    );

endmodule

// File: rtl/vbs_checker.sv
// Module: vbs_checker
// Temporal checks on the shifter's ports, attached to every instance by bind.
// Assumes the default of 128-bit lanes for the upper-bit boundaries.
module vbs_checker #(
    parameter int VEC_W   = 512,
    parameter int COUNT_W = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [VEC_W-1:0]   old_dst,
    input logic [COUNT_W-1:0] count,
    input logic [1:0]         vlen,
    input logic               legacy,
    input logic               out_valid,
    input logic [VEC_W-1:0]   result
);
    localparam int LW = 128;

    if (REG_OUT) begin : g_reg
        // R9
        valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R9
        valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R10
        hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(result));
        // R2
        sat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && count > COUNT_W'(15) && !(vlen == 2'd0 && legacy))
            |=> (result == '0));
        // R4
        upper_256_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && vlen == 2'd1) |=> (result[VEC_W-1:2*LW] == '0));
        // R5
        upper_128_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && vlen == 2'd0 && !legacy) |=> (result[VEC_W-1:LW] == '0));
        // R6
        legacy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && vlen == 2'd0 && legacy)
            |=> (result[VEC_W-1:LW] == $past(old_dst[VEC_W-1:LW])));
    end else begin : g_comb
        // R12
        comb_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> out_valid);
        // R2
        comb_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (count > COUNT_W'(15) && !(vlen == 2'd0 && legacy)) |-> (result == '0));
        // R6
        comb_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vlen == 2'd0 && legacy) |-> (result[VEC_W-1:LW] == old_dst[VEC_W-1:LW]));
        // R4
        comb_256_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vlen == 2'd1) |-> (result[VEC_W-1:2*LW] == '0));
    end

endmodule

bind vec_byte_shifter vbs_checker #(
    .VEC_W   (NUM_LANES*LANE_W),
    .COUNT_W (COUNT_W),
    .REG_OUT (REG_OUT)
) u_vbs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .old_dst   (old_dst),
    .count     (count),
    .vlen      (vlen),
    .legacy    (legacy),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_vec_byte_shifter.sv
`timescale 1ns/1ps
module tb_vec_byte_shifter;

    localparam int NCNT  = 6;
    localparam int NMODE = 7;
    // Stimulus table: counts, and modes as {vlen, legacy}.
    localparam logic [7:0] CNT_TAB  [NCNT]  = '{8'd0, 8'd1, 8'd9, 8'd15, 8'd16, 8'd255};
    localparam logic [2:0] MODE_TAB [NMODE] = '{3'b000, 3'b001, 3'b010, 3'b011,
                                                3'b100, 3'b101, 3'b111};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src = '0;
    logic [511:0] old_dst = '0;
    logic [7:0]   count = '0;
    logic [1:0]   vlen = '0;
    logic         legacy = 1'b0;
    logic         out_valid, out_valid_c;
    logic [511:0] result, result_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vec_byte_shifter #(.REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .old_dst(old_dst),
        .count(count), .vlen(vlen), .legacy(legacy), .out_valid(out_valid), .result(result));

    vec_byte_shifter #(.REG_OUT(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .old_dst(old_dst),
        .count(count), .vlen(vlen), .legacy(legacy), .out_valid(out_valid_c), .result(result_c));

    // Reference model over per-lane byte arrays.
    function automatic logic [511:0] ref_model(input logic [511:0] s, input logic [511:0] o,
                                               input logic [7:0] c, input logic [1:0] vl,
                                               input logic lg);
        logic [7:0] sb [4][16];
        logic [7:0] ob [4][16];
        logic [7:0] rb [4][16];
        logic [511:0] r;
        int nl;
        bit inplace;
        inplace = (vl == 2'd0) && lg;
        nl = (vl == 2'd0) ? 1 : ((vl == 2'd1) ? 2 : 4);
        for (int l = 0; l < 4; l++) begin
            for (int b = 0; b < 16; b++) begin
                sb[l][b] = s[(l*16+b)*8 +: 8];
                ob[l][b] = o[(l*16+b)*8 +: 8];
            end
        end
        for (int l = 0; l < 4; l++) begin
            for (int b = 0; b < 16; b++) begin
                if (l < nl) begin
                    if (c > 8'd15 || b < int'(c)) rb[l][b] = 8'h00;
                    else rb[l][b] = inplace ? ob[l][b-int'(c)] : sb[l][b-int'(c)];
                end else begin
                    rb[l][b] = inplace ? ob[l][b] : 8'h00;
                end
            end
        end
        for (int l = 0; l < 4; l++)
            for (int b = 0; b < 16; b++)
                r[(l*16+b)*8 +: 8] = rb[l][b];
        return r;
    endfunction

    function automatic logic [511:0] pattern(input int seed, input int mul);
        logic [511:0] p;
        for (int b = 0; b < 64; b++) p[b*8 +: 8] = 8'((b * mul + seed * 13 + 1) & 8'hff);
        return p;
    endfunction

    task automatic check_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [7:0] c, input logic [2:0] m);
        if (c > 8'd15 && m != 3'b001) return "R2";
        case (m)
            3'b000:  return "R5";
            3'b001:  return "R6";
            3'b010:  return "R4";
            3'b011:  return "R7";
            3'b100:  return "R3";
            3'b101:  return "R7";
            default: return "R8";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [511:0] exp;
        logic [511:0] held;
        // R11: reset clears the register stage even with a strobe present.
        in_valid = 1'b1;
        src = pattern(3, 7);
        count = 8'd2;
        repeat (3) @(negedge clk);
        check_vec("R11 reset result", result, '0);
        check_bit("R11 reset valid", out_valid, 1'b0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R9 idle valid", out_valid, 1'b0);

        // Table walk over counts and modes.
        for (int v = 0; v < NCNT * NMODE; v++) begin
            logic [7:0] c;
            logic [2:0] m;
            c = CNT_TAB[v % NCNT];
            m = MODE_TAB[v / NCNT];
            src = pattern(v, 37);
            old_dst = pattern(v + 100, 53);
            count = c;
            vlen = m[2:1];
            legacy = m[0];
            in_valid = 1'b1;
            exp = ref_model(src, old_dst, c, m[2:1], m[0]);
            #1;
            check_vec({tag_of(c, m), " R12 comb"}, result_c, exp);
            check_bit("R12 comb valid", out_valid_c, 1'b1);
            check_bit("R9 not yet valid", out_valid, 1'b0);
            @(negedge clk);
            check_vec({tag_of(c, m), " R9 reg"}, result, exp);
            check_bit("R9 reg valid", out_valid, 1'b1);
            in_valid = 1'b0;
            @(negedge clk);
        end

        // R1: byte placement in every lane, walking-byte lanes in 512 mode.
        src = pattern(7, 1);
        old_dst = '1;
        vlen = 2'd2;
        legacy = 1'b0;
        count = 8'd5;
        in_valid = 1'b1;
        exp = ref_model(src, old_dst, 8'd5, 2'd2, 1'b0);
        @(negedge clk);
        check_vec("R1 byte move", result, exp);
        check_bit("R1 lane1 byte5", result[128+5*8 +: 8] === src[128 +: 8], 1'b1);
        check_bit("R3 no cross lane2 byte0", result[256 +: 8] === 8'h00, 1'b1);

        // R6: src has no effect in legacy 128 mode.
        vlen = 2'd0;
        legacy = 1'b1;
        count = 8'd3;
        old_dst = pattern(9, 11);
        src = pattern(1, 3);
        exp = ref_model(src, old_dst, 8'd3, 2'd0, 1'b1);
        @(negedge clk);
        check_vec("R6 src A", result, exp);
        src = ~src;
        @(negedge clk);
        check_vec("R6 src B", result, exp);

        // R10: result holds while in_valid is low and inputs move.
        held = result;
        in_valid = 1'b0;
        src = pattern(20, 5);
        old_dst = pattern(21, 9);
        count = 8'd0;
        vlen = 2'd2;
        @(negedge clk);
        check_vec("R10 hold 1", result, held);
        check_bit("R10 valid low", out_valid, 1'b0);
        @(negedge clk);
        check_vec("R10 hold 2", result, held);

        // R11: reset in mid-run clears the stage.
        rst_n = 1'b0;
        @(negedge clk);
        check_vec("R11 mid reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule